// File: doc/BRIEF.md
# Data Breakpoint Match Unit

This block watches a stream of data accesses and compares each one against a small set of programmable breakpoint slots. Each slot holds an address, a naturally aligned watch size, an access-type filter and an enable bit. When an access touches any byte that a slot watches, the slot is hit. If at least one hit slot is enabled, every hit slot is flagged in a sticky status word, and a one-cycle trap request is raised toward the core.

An access is described by its start address and a byte count from 1 to 10, so a ten-byte floating-point store is covered end to end. The byte range is compared as a whole, so an access that runs across a 64-byte line or a page boundary is checked on both sides of the boundary. Accesses that belong to a repeated string instruction accumulate their hits. The trap for those is deferred until the end-of-iteration strobe, and status flags from earlier iterations are never overwritten by later ones. Software programs the slots and clears the status through a simple select/write/read port.

Top module: `hwbp_unit`

## Requirements
- R1: Slot i is hit when its aligned window [A & ~(S-1), (A & ~(S-1)) + S - 1] overlaps any byte of the access range [addr, addr + len - 1], for len from 1 to 10. This includes ranges that cross a line or page boundary and the ninth and tenth bytes of a ten-byte store. A length of 0 hits nothing.
- R2: Control bit 4+i selects the type filter of slot i: 0 watches writes only, 1 watches reads and writes.
- R3: Software select 0..3 addresses the slot address registers, 4 the control register and 5 the status register. Control bits 3:0 are the per-slot enables. Control bits [9+2i:8+2i] are the size code of slot i, where code 0, 1, 2, 3 means 1, 2, 4, 8 bytes. Reads return the written address and control values.
- R4: When an access hits at least one enabled slot, every hit slot is flagged in status bits 3:0, whether enabled or not. When no hit slot is enabled, the status is unchanged and no trap follows.
- R5: Status reads as 0xFFFF0FF0 OR the four flags. A hit on slots 0 and 2 reads 0xFFFF0FF5.
- R6: Flags are sticky. Only a write to select 5 changes them, and that write loads bits 3:0 of the write data. Hits taken in the same cycle are ORed on top.
- R7: For an access not marked as repeated, trap_o is high for exactly the one cycle after the access cycle when an enabled slot was hit.
- R8: For accesses marked as repeated, no trap is raised per access. Flags accumulate across iterations. trap_o pulses the cycle after iter_end_i if any repeated access since the previous strobe (including one in the strobe cycle) hit an enabled slot.
- R9: The uncached-access flag has no effect on matching, status or trap.
- R10: After reset, status reads 0xFFFF0FF0, trap_o is low, and the control and address registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 32 | Start byte address of the access |
| acc_len_i | input | 4 | Byte count of the access, 1 to 10 |
| acc_write_i | input | 1 | 1 for a store, 0 for a load |
| acc_uncached_i | input | 1 | Access targets uncached memory |
| acc_rep_i | input | 1 | Access is one iteration of a repeated string operation |
| iter_end_i | input | 1 | End of a repeated-operation iteration |
| sw_we_i | input | 1 | Software write strobe |
| sw_sel_i | input | 3 | Software register select |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Software read data for the current select |
| trap_o | output | 1 | One-cycle debug trap request |
| status_o | output | 32 | Status word with reserved bits set |

## Verification
A table of single accesses is run against a fixed four-slot setup. The table probes windows of each size, both edges of each window, the upper half of accesses split over a line and over a page, and the last two bytes of ten-byte stores. It also includes reads against write-only slots and uncached loads, which separates overlap arithmetic errors from type-filter errors. Directed sequences then enable a single slot, to show that a disabled slot is still reported alongside an enabled one but never traps alone. Further sequences run repeated iterations that hit different slot sets and prove that the flags only grow and the trap waits for the strobe. A final check writes a nonzero status value, to tell a sticky OR from an overwrite.

// File: rtl/hwbp_pkg.sv
package hwbp_pkg;

  // Reserved status bits that always read as one.
  localparam logic [31:0] STATUS_RSVD = 32'hFFFF_0FF0;

  // Watch-size code of a slot.
  typedef enum logic [1:0] {
    WATCH_1B = 2'd0,
    WATCH_2B = 2'd1,
    WATCH_4B = 2'd2,
    WATCH_8B = 2'd3
  } watch_size_e;

endpackage

// File: rtl/hwbp_slot.sv
module hwbp_slot #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] bp_addr_i,
  input  logic [1:0]        size_code_i,
  input  logic              rw_type_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [LEN_W-1:0]  acc_len_i,
  input  logic              acc_write_i,
  output logic              hit_o
);
  typedef logic [ADDR_W:0] wide_t;

  function automatic wide_t watch_span(input logic [1:0] code);
    return wide_t'(1) << code;
  endfunction

  function automatic logic ranges_meet(input wide_t lo_a, input wide_t hi_a,
                                       input wide_t lo_b, input wide_t hi_b);
    return (lo_a <= hi_b) && (lo_b <= hi_a);
  endfunction

  wide_t span, win_lo, win_hi, acc_lo, acc_hi;
  logic  type_ok, nonempty;

  always_comb begin
    span     = watch_span(size_code_i);
    win_lo   = wide_t'(bp_addr_i) & ~(span - wide_t'(1));
    win_hi   = win_lo + span - wide_t'(1);
    acc_lo   = wide_t'(acc_addr_i);
    acc_hi   = acc_lo + wide_t'(acc_len_i) - wide_t'(1);
    nonempty = (acc_len_i != '0);
    type_ok  = acc_write_i | rw_type_i;
    hit_o    = nonempty & type_ok & ranges_meet(win_lo, win_hi, acc_lo, acc_hi);
  end
endmodule

// File: rtl/hwbp_track.sv
module hwbp_track #(
  parameter int NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic              acc_rep_i,
  input  logic              iter_end_i,
  input  logic [NUM_BP-1:0] hit_vec_i,
  input  logic              hit_en_any_i,
  input  logic              flag_we_i,
  input  logic [NUM_BP-1:0] flag_wdata_i,
  output logic [NUM_BP-1:0] flags_o,
  output logic              trap_o
);
  logic [NUM_BP-1:0] flags_q, flags_d;
  logic pend_q, pend_d, trap_d, take, take_rep;

  always_comb begin
    take     = acc_valid_i & hit_en_any_i;
    take_rep = take & acc_rep_i;
    flags_d  = (flag_we_i ? flag_wdata_i : flags_q) | (take ? hit_vec_i : '0);
    pend_d   = iter_end_i ? 1'b0 : (pend_q | take_rep);
    trap_d   = (take & ~acc_rep_i) | (iter_end_i & (pend_q | take_rep));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pend_q  <= 1'b0;
      trap_o  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      pend_q  <= pend_d;
      trap_o  <= trap_d;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/hwbp_unit.sv
module hwbp_unit #(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 32,
  localparam int SEL_W = $clog2(NUM_BP + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [LEN_W-1:0]  acc_len_i,
  input  logic              acc_write_i,
  input  logic              acc_uncached_i,
  input  logic              acc_rep_i,
  input  logic              iter_end_i,
  input  logic              sw_we_i,
  input  logic [SEL_W-1:0]  sw_sel_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  output logic [DATA_W-1:0] sw_rdata_o,
  output logic              trap_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int CTRL_W = 4 * NUM_BP;
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_BP);
  localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_BP + 1);

  logic [ADDR_W-1:0] bp_addr_q [NUM_BP];
  logic [CTRL_W-1:0] ctrl_q;
  logic [NUM_BP-1:0] hit_vec, en_mask, hit_en_vec, flags;
  logic              hit_en_any, stat_we;

  // Uncached loads go through exactly the same compare path (R9).
  logic unused_uc;
  assign unused_uc = acc_uncached_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < NUM_BP; i++) bp_addr_q[i] <= '0;
    end else if (sw_we_i) begin
      if (sw_sel_i == SEL_CTRL) ctrl_q <= sw_wdata_i[CTRL_W-1:0];
      for (int i = 0; i < NUM_BP; i++)
        if (sw_sel_i == SEL_W'(i)) bp_addr_q[i] <= sw_wdata_i[ADDR_W-1:0];
    end
  end

  assign en_mask = ctrl_q[NUM_BP-1:0];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
    hwbp_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slot (
      .bp_addr_i   (bp_addr_q[g]),
      .size_code_i (ctrl_q[2*NUM_BP + 2*g +: 2]),
      .rw_type_i   (ctrl_q[NUM_BP + g]),
      .acc_addr_i  (acc_addr_i),
      .acc_len_i   (acc_len_i),
      .acc_write_i (acc_write_i),
      .hit_o       (hit_vec[g])
    );
  end

  assign hit_en_vec = hit_vec & en_mask;
  assign hit_en_any = |hit_en_vec;
  assign stat_we    = sw_we_i & (sw_sel_i == SEL_STAT);

  hwbp_track #(.NUM_BP(NUM_BP)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid_i  (acc_valid_i),
    .acc_rep_i    (acc_rep_i),
    .iter_end_i   (iter_end_i),
    .hit_vec_i    (hit_vec),
    .hit_en_any_i (hit_en_any),
    .flag_we_i    (stat_we),
    .flag_wdata_i (sw_wdata_i[NUM_BP-1:0]),
    .flags_o      (flags),
    .trap_o       (trap_o)
  );

  assign status_o = DATA_W'(hwbp_pkg::STATUS_RSVD) | DATA_W'(flags);

  always_comb begin
    sw_rdata_o = '0;
    if (sw_sel_i == SEL_CTRL) sw_rdata_o = DATA_W'(ctrl_q);
    if (sw_sel_i == SEL_STAT) sw_rdata_o = status_o;
    for (int i = 0; i < NUM_BP; i++)
      if (sw_sel_i == SEL_W'(i)) sw_rdata_o = DATA_W'(bp_addr_q[i]);
  end
endmodule

// File: rtl/hwbp_unit_chk.sv
module hwbp_unit_chk #(
  parameter int NUM_BP = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid_i,
  input logic              acc_rep_i,
  input logic              iter_end_i,
  input logic              stat_we,
  input logic [DATA_W-1:0] sw_wdata_i,
  input logic [NUM_BP-1:0] hit_vec,
  input logic              hit_en_any,
  input logic              trap_o,
  input logic [DATA_W-1:0] status_o
);
  // R7: a trap only follows a plain access or an iteration strobe.
  a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past((acc_valid_i && !acc_rep_i) || iter_end_i));

  // R4: an access with no enabled hit does not trap.
  a_r4_no_enabled_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_rep_i && !iter_end_i && !hit_en_any) |=> !trap_o);

  // R4: all hit slots get flagged when any enabled slot hits.
  a_r4_all_hits_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && hit_en_any) |=>
      ((status_o[NUM_BP-1:0] & $past(hit_vec)) == $past(hit_vec)));

  // R6: without a status write, flags never drop.
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stat_we) |-> ((status_o & $past(status_o)) == $past(status_o)));

  // R6: a status write with no access loads the written flags.
  a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !acc_valid_i) |=>
      (status_o[NUM_BP-1:0] == $past(sw_wdata_i[NUM_BP-1:0])));

  // R8: repeated accesses never trap on their own.
  a_r8_rep_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_rep_i && !iter_end_i) |=> !trap_o);
endmodule

bind hwbp_unit hwbp_unit_chk #(.NUM_BP(NUM_BP), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid_i (acc_valid_i),
  .acc_rep_i   (acc_rep_i),
  .iter_end_i  (iter_end_i),
  .stat_we     (stat_we),
  .sw_wdata_i  (sw_wdata_i),
  .hit_vec     (hit_vec),
  .hit_en_any  (hit_en_any),
  .trap_o      (trap_o),
  .status_o    (status_o)
);

// File: tb/hwbp_unit_tb.sv
module hwbp_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;
  localparam logic [31:0] CTRL_ALL = 32'h0000_325F;
  localparam int NVEC = 16;
  // {addr, len, write, uncached, expected trap, expected flags}
  localparam logic [42:0] VECS [NVEC] = '{
    {32'h0000_1000, 4'd1,  1'b0, 1'b0, 1'b1, 4'b0101},
    {32'h0000_1006, 4'd2,  1'b0, 1'b0, 1'b1, 4'b0100},
    {32'h0000_1004, 4'd4,  1'b1, 1'b0, 1'b1, 4'b0100},
    {32'h0000_0FFE, 4'd2,  1'b0, 1'b0, 1'b0, 4'b0000},
    {32'h0000_0FFF, 4'd2,  1'b0, 1'b0, 1'b1, 4'b0101},
    {32'h0000_203C, 4'd8,  1'b1, 1'b0, 1'b1, 4'b0010},
    {32'h0000_203C, 4'd8,  1'b0, 1'b0, 1'b0, 4'b0000},
    {32'h0000_2040, 4'd1,  1'b1, 1'b0, 1'b1, 4'b0010},
    {32'h0000_3000, 4'd10, 1'b1, 1'b0, 1'b1, 4'b1000},
    {32'h0000_3000, 4'd9,  1'b1, 1'b0, 1'b0, 4'b0000},
    {32'h0000_3008, 4'd2,  1'b1, 1'b0, 1'b1, 4'b1000},
    {32'h0000_3000, 4'd10, 1'b0, 1'b0, 1'b0, 4'b0000},
    {32'h0000_1002, 4'd1,  1'b0, 1'b1, 1'b1, 4'b0101},
    {32'h0000_3000, 4'd10, 1'b1, 1'b1, 1'b1, 4'b1000},
    {32'h0000_1008, 4'd4,  1'b1, 1'b0, 1'b0, 4'b0000},
    {32'h0000_0FFC, 4'd10, 1'b1, 1'b0, 1'b1, 4'b0101}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid_i = 0, acc_write_i = 0, acc_uncached_i = 0, acc_rep_i = 0;
  logic iter_end_i = 0, sw_we_i = 0;
  logic [31:0] acc_addr_i = '0, sw_wdata_i = '0;
  logic [3:0]  acc_len_i = '0;
  logic [2:0]  sw_sel_i = SEL_CTRL;
  logic [31:0] sw_rdata_o, status_o;
  logic        trap_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwbp_unit u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); sw_we_i = 1; sw_sel_i = sel; sw_wdata_i = d;
    @(negedge clk); sw_we_i = 0;
  endtask

  task automatic sw_rd(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk); sw_sel_i = sel; #1; d = sw_rdata_o;
  endtask

  task automatic access(input logic [31:0] a, input logic [3:0] n, input logic wr,
                        input logic uc, input logic rep);
    @(negedge clk);
    acc_valid_i = 1; acc_addr_i = a; acc_len_i = n;
    acc_write_i = wr; acc_uncached_i = uc; acc_rep_i = rep;
    @(negedge clk); acc_valid_i = 0; acc_rep_i = 0;
  endtask

  task automatic strobe_end();
    @(negedge clk); iter_end_i = 1;
    @(negedge clk); iter_end_i = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 status", status_o, 32'hFFFF_0FF0);
    check("R10 trap", 32'(trap_o), 32'd0);
    check("R10 ctrl", sw_rdata_o, 32'd0);
    rst_n = 1;

    sw_wr(3'd0, 32'h0000_1000);
    sw_wr(3'd1, 32'h0000_2040);
    sw_wr(3'd2, 32'h0000_1004);
    sw_wr(3'd3, 32'h0000_3009);
    sw_wr(SEL_CTRL, CTRL_ALL);
    sw_rd(SEL_CTRL, rd); check("R3 ctrl readback", rd, CTRL_ALL);
    sw_rd(3'd1, rd);     check("R3 addr readback", rd, 32'h0000_2040);

    // R1 R2 R5 R7 R9: table of single accesses
    for (int k = 0; k < NVEC; k++) begin
      sw_wr(SEL_STAT, 32'd0);
      access(VECS[k][42:11], VECS[k][10:7], VECS[k][6], VECS[k][5], 1'b0);
      check($sformatf("R1/R7 vec%0d trap", k), 32'(trap_o), 32'(VECS[k][4]));
      check($sformatf("R1/R5 vec%0d status", k), status_o,
            32'hFFFF_0FF0 | 32'(VECS[k][3:0]));
    end

    // R7: the trap lasts a single cycle
    sw_wr(SEL_STAT, 32'd0);
    access(32'h0000_1000, 4'd1, 1'b0, 1'b0, 1'b0);
    check("R7 trap pulse", 32'(trap_o), 32'd1);
    @(negedge clk); check("R7 trap drops", 32'(trap_o), 32'd0);

    // R4: only slot 0 enabled
    sw_wr(SEL_CTRL, 32'h0000_3251);
    sw_wr(SEL_STAT, 32'd0);
    access(32'h0000_1000, 4'd1, 1'b0, 1'b0, 1'b0);
    check("R4 disabled slot reported", status_o, 32'hFFFF_0FF5);
    check("R4 trap on enabled", 32'(trap_o), 32'd1);
    sw_wr(SEL_STAT, 32'd0);
    access(32'h0000_1006, 4'd2, 1'b0, 1'b0, 1'b0);
    check("R4 disabled alone no trap", 32'(trap_o), 32'd0);
    check("R4 disabled alone no flag", status_o, 32'hFFFF_0FF0);
    sw_wr(SEL_CTRL, CTRL_ALL);

    // R8: repeated operation, flags accumulate, trap waits for strobe
    sw_wr(SEL_STAT, 32'd0);
    access(32'h0000_1000, 4'd1, 1'b0, 1'b0, 1'b1);
    check("R8 no early trap", 32'(trap_o), 32'd0);
    check("R8 first iteration", status_o, 32'hFFFF_0FF5);
    access(32'h0000_1006, 4'd1, 1'b0, 1'b0, 1'b1);
    check("R8 no early trap 2", 32'(trap_o), 32'd0);
    check("R8 flags kept", status_o, 32'hFFFF_0FF5);
    strobe_end();
    check("R8 trap at strobe", 32'(trap_o), 32'd1);
    check("R8 flags after strobe", status_o, 32'hFFFF_0FF5);
    sw_wr(SEL_STAT, 32'd0);
    access(32'h0000_5000, 4'd4, 1'b1, 1'b0, 1'b1);
    strobe_end();
    check("R8 no hit no trap", 32'(trap_o), 32'd0);

    // R6: status write loads, later hits OR in
    sw_wr(SEL_STAT, 32'h0000_0003);
    check("R6 write loads", status_o, 32'hFFFF_0FF3);
    access(32'h0000_1008, 4'd4, 1'b1, 1'b0, 1'b0);
    check("R6 miss keeps", status_o, 32'hFFFF_0FF3);
    access(32'h0000_3009, 4'd1, 1'b1, 1'b0, 1'b0);
    check("R6 hit ORs in", status_o, 32'hFFFF_0FFB);
    sw_rd(SEL_STAT, rd); check("R5 status readback", rd, 32'hFFFF_0FFB);

    report();
  end
endmodule